// File: doc/BRIEF.md
# Non-Excepting Load Fault Checker

This block judges a speculative load before it reaches memory. It forms the effective address from a base register value plus either an index register value or a sign-extended immediate. It tests that address against the natural alignment of the access size, and it tests the destination register number against the register alignment that wide accesses need. A fault does not trap. Instead a per-register "not-excepting" flag is set on the destination, so the fault is deferred. When there is no fault, a flag already set on a source register is passed on to the destination and the load is withheld. Integer and floating-point destinations keep separate flag banks.

When fault logging is configured as valid and enabled, every checked load takes the lowest-numbered free entry of a small bank of status slots below a programmable slot count. The entry stores what the load was, why it faulted, and the address it used. If no slot is free, a logging-overflow indication is raised and nothing is written. The memory access and the register file reads sit outside the block. Register values and indices arrive as inputs. The verdict leaves as a registered response one cycle after the request.

Top module: `nel_fault_checker`

## Requirements
- R1: The effective address is `req_base_val` plus `req_index_val` when `req_use_index` is 1, otherwise plus `req_imm` sign-extended. Access size codes on `req_size`: 0 byte, 1 halfword, 2 word, 3 doubleword, 4 quadword (5 to 7 behave as byte). A memory-alignment fault occurs when the address bits below log2 of the access width in bytes are not all zero. Byte accesses never fault.
- R2: A register-alignment fault occurs for a doubleword whose `req_dst_idx` is odd, and for a quadword whose `req_dst_idx` is not a multiple of 4.
- R3: When either fault occurs, the destination flag is set and `rsp_proceed` is 1.
- R4: Without a fault, if the flag of the base register is set, or the flag of the index register is set while `req_use_index` is 1, the destination flag is set and `rsp_proceed` is 0. The index flag is ignored when `req_use_index` is 0.
- R5: Without a fault and with clean sources, the destination flag is cleared and `rsp_proceed` is 1.
- R6: `req_is_float`=1 selects the floating-point bank (`fp_ne_flags`) for both the source lookup and the destination update. Otherwise the integer bank (`int_ne_flags`) is used. The other bank is left unchanged.
- R7: A request with `log_ctl_valid`=1 and `log_enable`=1 writes the lowest-index slot whose valid bit is clear and whose index is below `log_slot_limit`. Requests without both enables write no slot.
- R8: A slot record read on `slot_rd_status` has this layout: bit 0 valid=1, bit 1 address-valid=1, bit 2 memory-misalignment cause, bit 3 register-misalignment cause, bit 4 float flag, bits 7:5 size code, bits 10:8 the slot's own index, bits 16:11 destination register. `slot_rd_addr` returns the effective address of the slot selected by `slot_rd_sel`.
- R9: The two cause bits of a newly written slot are each 1 only if the matching fault occurred on that load. Otherwise they are 0.
- R10: A logging request that finds no free slot below the limit sets `rsp_log_ovf` to 1 in its response and writes no slot.
- R11: `rsp_valid` is 1 exactly one cycle after each accepted `req_valid`. After reset all flags are 0, all slots read 0, and `rsp_valid`, `rsp_proceed` and `rsp_log_ovf` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A load is presented this cycle |
| req_size | input | 3 | Access size code |
| req_base_idx | input | REG_W | Base register number |
| req_base_val | input | ADDR_W | Base register value |
| req_use_index | input | 1 | Add the index register instead of the immediate |
| req_index_idx | input | REG_W | Index register number |
| req_index_val | input | ADDR_W | Index register value |
| req_imm | input | IMM_W | Signed immediate displacement |
| req_dst_idx | input | REG_W | Destination register number |
| req_is_float | input | 1 | Destination is a floating-point register |
| log_ctl_valid | input | 1 | Logging control is valid |
| log_enable | input | 1 | Logging enabled |
| log_slot_limit | input | CNT_W | Number of usable slots |
| slot_rd_sel | input | SLOT_W | Slot selected for observation |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_proceed | output | 1 | The load may be performed |
| rsp_log_ovf | output | 1 | Logging found no free slot |
| int_ne_flags | output | NUM_REGS | Integer not-excepting flags |
| fp_ne_flags | output | NUM_REGS | Floating-point not-excepting flags |
| slot_rd_status | output | REC_W | Record of the selected slot |
| slot_rd_addr | output | ADDR_W | Address stored in the selected slot |

## Verification
The hardest case to reach is propagation without a fault. It needs a source register whose flag is already set, and only an earlier faulting load can set one. The stimulus therefore first plants a fault on a chosen destination, then reuses that register as base, and then as an index with the index select both off and on. Slot exhaustion is reached the same way: the limit is lowered to three, enough loads fill those slots, and a further load must report overflow while the slot just above the limit stays empty until the limit is raised.

// File: rtl/nel_pkg.sv
package nel_pkg;

  typedef enum logic [2:0] {
    SZ_BYTE  = 3'd0,
    SZ_HALF  = 3'd1,
    SZ_WORD  = 3'd2,
    SZ_DWORD = 3'd3,
    SZ_QUAD  = 3'd4
  } acc_size_e;

  // Address alignment test on the four low address bits.
  function automatic logic addr_misaligned(input logic [2:0] sz, input logic [3:0] low);
    logic r;
    case (sz)
      SZ_HALF:  r = low[0];
      SZ_WORD:  r = |low[1:0];
      SZ_DWORD: r = |low[2:0];
      SZ_QUAD:  r = |low;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

  // Destination register alignment for wide accesses.
  function automatic logic dst_misaligned(input logic [2:0] sz, input logic [1:0] dlow);
    logic r;
    case (sz)
      SZ_DWORD: r = dlow[0];
      SZ_QUAD:  r = |dlow;
      default:  r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/nel_fault_eval.sv
module nel_fault_eval
  import nel_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12,
  parameter int REG_W  = 6
) (
  input  logic [ADDR_W-1:0] base_val_i,
  input  logic [ADDR_W-1:0] index_val_i,
  input  logic              use_index_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [2:0]        size_i,
  input  logic [REG_W-1:0]  dst_i,
  output logic [ADDR_W-1:0] eff_addr_o,
  output logic              mem_fault_o,
  output logic              reg_fault_o
);
  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] disp;

  always_comb begin
    if (use_index_i) disp = index_val_i;
    else             disp = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  end

  assign eff_addr_o  = base_val_i + disp;
  assign mem_fault_o = addr_misaligned(size_i, eff_addr_o[3:0]);
  assign reg_fault_o = dst_misaligned(size_i, dst_i[1:0]);

endmodule

// File: rtl/nel_flag_bank.sv
module nel_flag_bank #(
  parameter int NUM_REGS = 64,
  parameter int REG_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en_i,
  input  logic                is_float_i,
  input  logic [REG_W-1:0]    dst_i,
  input  logic [REG_W-1:0]    base_i,
  input  logic [REG_W-1:0]    index_i,
  input  logic                use_index_i,
  input  logic                fault_i,
  output logic                suppress_o,
  output logic [NUM_REGS-1:0] int_flags_o,
  output logic [NUM_REGS-1:0] fp_flags_o
);
  localparam int NUM_BANKS = 2;

  logic [NUM_BANKS-1:0][NUM_REGS-1:0] bank_vec;
  logic [NUM_REGS-1:0] sel_bank;
  logic                src_flag;
  logic                dst_next;

  assign sel_bank   = bank_vec[is_float_i];
  assign src_flag   = sel_bank[base_i] | (use_index_i & sel_bank[index_i]);
  assign dst_next   = fault_i | src_flag;
  assign suppress_o = ~fault_i & src_flag;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [NUM_REGS-1:0] flags_q;
    logic                hit;
    assign hit = upd_en_i && (is_float_i == (b == 1));
    always_ff @(posedge clk) begin
      if (!rst_n)   flags_q <= '0;
      else if (hit) flags_q[dst_i] <= dst_next;
    end
    assign bank_vec[b] = flags_q;
  end

  assign int_flags_o = bank_vec[0];
  assign fp_flags_o  = bank_vec[1];

  // R3
  fault_sets_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i && fault_i && !is_float_i |=> int_flags_o[$past(dst_i)]);

  // R5
  clean_clears_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i && !fault_i && !src_flag && !is_float_i |=> !int_flags_o[$past(dst_i)]);

  // R6
  bank_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i && !is_float_i |=> fp_flags_o == $past(fp_flags_o));

endmodule

// File: rtl/nel_slot_bank.sv
module nel_slot_bank #(
  parameter int ADDR_W    = 32,
  parameter int NUM_SLOTS = 8,
  parameter int REG_W     = 6,
  parameter int SLOT_W    = 3,
  parameter int CNT_W     = 4,
  parameter int REC_W     = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              log_req_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [2:0]        size_i,
  input  logic              is_float_i,
  input  logic              mem_fault_i,
  input  logic              reg_fault_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SLOT_W-1:0] rd_sel_i,
  output logic              alloc_fire_o,
  output logic              ovf_o,
  output logic [REC_W-1:0]  rd_status_o,
  output logic [ADDR_W-1:0] rd_addr_o
);
  // Record field positions; the readers of the record depend on these.
  localparam int F_VALID = 0;
  localparam int F_AV    = 1;
  localparam int F_MEM   = 2;
  localparam int F_REG   = 3;
  localparam int F_FLT   = 4;
  localparam int F_SZ    = 5;
  localparam int F_SLOT  = 8;
  localparam int F_DST   = F_SLOT + SLOT_W;

  logic [REC_W-1:0]  rec_q  [NUM_SLOTS];
  logic [ADDR_W-1:0] addr_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] valid_vec;
  logic [NUM_SLOTS-1:0] wr_vec;
  logic                 found;
  logic [SLOT_W-1:0]    alloc_idx;
  logic [REC_W-1:0]     new_rec;

  // Lowest free slot below the limit.
  always_comb begin
    found     = 1'b0;
    alloc_idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!found && !valid_vec[i] && (CNT_W'(i) < limit_i)) begin
        found     = 1'b1;
        alloc_idx = SLOT_W'(i);
      end
    end
  end

  assign alloc_fire_o = log_req_i && found;
  assign ovf_o        = log_req_i && !found;

  always_comb begin
    new_rec                        = '0;
    new_rec[F_VALID]               = 1'b1;
    new_rec[F_AV]                  = 1'b1;
    new_rec[F_MEM]                 = mem_fault_i;
    new_rec[F_REG]                 = reg_fault_i;
    new_rec[F_FLT]                 = is_float_i;
    new_rec[F_SZ +: 3]             = size_i;
    new_rec[F_SLOT +: SLOT_W]      = alloc_idx;
    new_rec[F_DST +: REG_W]        = dst_i;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign wr_vec[s]    = alloc_fire_o && (alloc_idx == SLOT_W'(s));
    assign valid_vec[s] = rec_q[s][F_VALID];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rec_q[s]  <= '0;
        addr_q[s] <= '0;
      end else if (wr_vec[s]) begin
        rec_q[s]  <= new_rec;
        addr_q[s] <= addr_i;
      end
    end
  end

  assign rd_status_o = rec_q[rd_sel_i];
  assign rd_addr_o   = addr_q[rd_sel_i];

  // R7
  alloc_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

  // R7
  alloc_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire_o |-> !valid_vec[alloc_idx] && ({1'b0, alloc_idx} < {1'b0, limit_i}));

  // R8
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(valid_vec) & ~valid_vec) == '0);

  // R10
  ovf_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> valid_vec == $past(valid_vec));

endmodule

// File: rtl/nel_fault_checker.sv
module nel_fault_checker #(
  parameter int ADDR_W    = 32,
  parameter int IMM_W     = 12,
  parameter int NUM_REGS  = 64,
  parameter int NUM_SLOTS = 8,
  localparam int REG_W    = $clog2(NUM_REGS),
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int CNT_W    = $clog2(NUM_SLOTS + 1),
  localparam int REC_W    = 8 + SLOT_W + REG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [2:0]          req_size,
  input  logic [REG_W-1:0]    req_base_idx,
  input  logic [ADDR_W-1:0]   req_base_val,
  input  logic                req_use_index,
  input  logic [REG_W-1:0]    req_index_idx,
  input  logic [ADDR_W-1:0]   req_index_val,
  input  logic [IMM_W-1:0]    req_imm,
  input  logic [REG_W-1:0]    req_dst_idx,
  input  logic                req_is_float,
  input  logic                log_ctl_valid,
  input  logic                log_enable,
  input  logic [CNT_W-1:0]    log_slot_limit,
  input  logic [SLOT_W-1:0]   slot_rd_sel,
  output logic                rsp_valid,
  output logic                rsp_proceed,
  output logic                rsp_log_ovf,
  output logic [NUM_REGS-1:0] int_ne_flags,
  output logic [NUM_REGS-1:0] fp_ne_flags,
  output logic [REC_W-1:0]    slot_rd_status,
  output logic [ADDR_W-1:0]   slot_rd_addr
);
  logic [ADDR_W-1:0] eff_addr;
  logic              mem_fault;
  logic              reg_fault;
  logic              any_fault;
  logic              suppress;
  logic              log_req;
  logic              alloc_fire;
  logic              log_ovf;

  nel_fault_eval #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .REG_W(REG_W)) eval_i (
    .base_val_i (req_base_val),
    .index_val_i(req_index_val),
    .use_index_i(req_use_index),
    .imm_i      (req_imm),
    .size_i     (req_size),
    .dst_i      (req_dst_idx),
    .eff_addr_o (eff_addr),
    .mem_fault_o(mem_fault),
    .reg_fault_o(reg_fault)
  );

  assign any_fault = mem_fault | reg_fault;
  assign log_req   = req_valid & log_ctl_valid & log_enable;

  nel_flag_bank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) flags_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en_i   (req_valid),
    .is_float_i (req_is_float),
    .dst_i      (req_dst_idx),
    .base_i     (req_base_idx),
    .index_i    (req_index_idx),
    .use_index_i(req_use_index),
    .fault_i    (any_fault),
    .suppress_o (suppress),
    .int_flags_o(int_ne_flags),
    .fp_flags_o (fp_ne_flags)
  );

  nel_slot_bank #(
    .ADDR_W(ADDR_W), .NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W),
    .SLOT_W(SLOT_W), .CNT_W(CNT_W), .REC_W(REC_W)
  ) slots_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .log_req_i   (log_req),
    .limit_i     (log_slot_limit),
    .dst_i       (req_dst_idx),
    .size_i      (req_size),
    .is_float_i  (req_is_float),
    .mem_fault_i (mem_fault),
    .reg_fault_i (reg_fault),
    .addr_i      (eff_addr),
    .rd_sel_i    (slot_rd_sel),
    .alloc_fire_o(alloc_fire),
    .ovf_o       (log_ovf),
    .rd_status_o (slot_rd_status),
    .rd_addr_o   (slot_rd_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_proceed <= 1'b0;
      rsp_log_ovf <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_proceed <= req_valid & ~suppress;
      rsp_log_ovf <= log_ovf;
    end
  end

  // R11
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && !rsp_log_ovf);

  // R3
  fault_proceeds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && any_fault |=> rsp_proceed);

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(alloc_fire && log_ovf));

endmodule

// File: tb/nel_fault_checker_tb.sv
module nel_fault_checker_tb_top;
  localparam int ADDR_W = 32, IMM_W = 12, NUM_REGS = 64, NUM_SLOTS = 8;
  localparam int REG_W = 6, SLOT_W = 3, CNT_W = 4, REC_W = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_size = '0;
  logic [REG_W-1:0] req_base_idx = '0, req_index_idx = '0, req_dst_idx = '0;
  logic [ADDR_W-1:0] req_base_val = '0, req_index_val = '0;
  logic req_use_index = 1'b0, req_is_float = 1'b0;
  logic [IMM_W-1:0] req_imm = '0;
  logic log_ctl_valid = 1'b0, log_enable = 1'b0;
  logic [CNT_W-1:0] log_slot_limit = '0;
  logic [SLOT_W-1:0] slot_rd_sel = '0;
  logic rsp_valid, rsp_proceed, rsp_log_ovf;
  logic [NUM_REGS-1:0] int_ne_flags, fp_ne_flags;
  logic [REC_W-1:0] slot_rd_status;
  logic [ADDR_W-1:0] slot_rd_addr;

  always #4 clk = ~clk;

  nel_fault_checker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_size(req_size),
    .req_base_idx(req_base_idx), .req_base_val(req_base_val),
    .req_use_index(req_use_index), .req_index_idx(req_index_idx),
    .req_index_val(req_index_val), .req_imm(req_imm), .req_dst_idx(req_dst_idx),
    .req_is_float(req_is_float), .log_ctl_valid(log_ctl_valid),
    .log_enable(log_enable), .log_slot_limit(log_slot_limit),
    .slot_rd_sel(slot_rd_sel), .rsp_valid(rsp_valid), .rsp_proceed(rsp_proceed),
    .rsp_log_ovf(rsp_log_ovf), .int_ne_flags(int_ne_flags),
    .fp_ne_flags(fp_ne_flags), .slot_rd_status(slot_rd_status),
    .slot_rd_addr(slot_rd_addr)
  );

  typedef struct {
    logic proceed;
    logic ovf;
    logic [NUM_REGS-1:0] iflags;
    logic [NUM_REGS-1:0] fflags;
    string tag;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [NUM_REGS-1:0] m_flags [2];
  logic [REC_W-1:0]    m_rec   [NUM_SLOTS];
  logic [ADDR_W-1:0]   m_addr  [NUM_SLOTS];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [REC_W-1:0] mk_rec(logic memf, logic regf, logic flt,
      logic [2:0] sz, int slot, logic [REG_W-1:0] dst);
    logic [REC_W-1:0] r;
    r = '0;
    r[0] = 1'b1; r[1] = 1'b1; r[2] = memf; r[3] = regf; r[4] = flt;
    r[7:5] = sz; r[10:8] = 3'(slot); r[16:11] = dst;
    return r;
  endfunction

  task automatic do_load(input string tag, input logic [2:0] sz,
      input int base, input logic [31:0] bval, input logic use_ix, input int ix,
      input logic [31:0] ixval, input int imm, input int dst, input logic flt);
    item_t it;
    logic [31:0] addr;
    logic memf, regf, src, found;
    int nbytes;
    @(negedge clk);
    req_valid = 1; req_size = sz; req_base_idx = 6'(base); req_base_val = bval;
    req_use_index = use_ix; req_index_idx = 6'(ix); req_index_val = ixval;
    req_imm = 12'(imm); req_dst_idx = 6'(dst); req_is_float = flt;
    addr = use_ix ? bval + ixval : bval + 32'(imm);
    nbytes = (sz <= 4) ? (1 << sz) : 1;
    memf = (addr % nbytes) != 0;
    regf = (sz == 3 && (dst % 2) != 0) || (sz == 4 && (dst % 4) != 0);
    src = m_flags[flt][base] || (use_ix && m_flags[flt][ix]);
    it.proceed = memf || regf || !src;
    m_flags[flt][dst] = memf || regf || src;
    it.ovf = 0;
    if (log_ctl_valid && log_enable) begin
      found = 0;
      for (int j = 0; j < NUM_SLOTS; j++) begin
        if (!found && j < log_slot_limit && !m_rec[j][0]) begin
          found = 1;
          m_rec[j] = mk_rec(memf, regf, flt, sz, j, 6'(dst));
          m_addr[j] = addr;
        end
      end
      it.ovf = !found;
    end
    it.iflags = m_flags[0];
    it.fflags = m_flags[1];
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic check_slot(input string tag, input int sel);
    @(negedge clk);
    slot_rd_sel = 3'(sel);
    #1;
    check({tag, " status"}, 64'(slot_rd_status), 64'(m_rec[sel]));
    check({tag, " addr"}, 64'(slot_rd_addr), 64'(m_addr[sel]));
  endtask

  // Monitor: compares each response against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        check("R11 unexpected response", 64'(1), 64'(0));
      end else begin
        item_t e;
        e = sb_q.pop_front();
        check({e.tag, " proceed"}, 64'(rsp_proceed), 64'(e.proceed));
        check({e.tag, " ovf"}, 64'(rsp_log_ovf), 64'(e.ovf));
        check({e.tag, " int flags"}, int_ne_flags, e.iflags);
        check({e.tag, " fp flags"}, fp_ne_flags, e.fflags);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_flags[0] = '0; m_flags[1] = '0;
    for (int j = 0; j < NUM_SLOTS; j++) begin m_rec[j] = '0; m_addr[j] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check("R11 rsp_valid after reset", 64'(rsp_valid), 64'(0));
    check("R11 proceed after reset", 64'(rsp_proceed), 64'(0));
    check("R11 int flags after reset", int_ne_flags, 64'(0));
    check("R11 fp flags after reset", fp_ne_flags, 64'(0));
    check_slot("R11 slot0 after reset", 0);

    // Logging enabled but control invalid: no slot may be written (R7)
    log_ctl_valid = 0; log_enable = 1; log_slot_limit = 4'd8;
    do_load("R1 byte odd addr", 3'd0, 1, 32'h1001, 0, 0, 0, 0, 2, 0);
    do_load("R1 R3 half odd", 3'd1, 1, 32'h1000, 0, 0, 0, 1, 3, 0);
    do_load("R1 word addr 2", 3'd2, 1, 32'h1000, 0, 0, 0, 2, 4, 0);
    do_load("R1 R5 word aligned", 3'd2, 1, 32'h1000, 0, 0, 0, 4, 5, 0);
    do_load("R1 dword addr 4", 3'd3, 1, 32'h1000, 0, 0, 0, 4, 6, 0);
    do_load("R1 quad addr 8", 3'd4, 1, 32'h1000, 0, 0, 0, 8, 8, 0);
    do_load("R1 quad aligned", 3'd4, 1, 32'h1000, 0, 0, 0, 16, 12, 0);
    do_load("R1 negative imm", 3'd4, 1, 32'h2010, 0, 0, 0, -16, 16, 0);
    do_load("R1 index added", 3'd2, 1, 32'h2000, 1, 2, 32'h2, 0, 17, 0);
    do_load("R2 dword odd dst", 3'd3, 1, 32'h2000, 0, 0, 0, 0, 7, 0);
    do_load("R2 quad dst 10", 3'd4, 1, 32'h2000, 0, 0, 0, 0, 10, 0);
    // Propagation from a flagged source (r3 was flagged above)
    do_load("R4 base flagged", 3'd0, 3, 32'h10, 0, 0, 0, 0, 20, 0);
    do_load("R4 index ignored", 3'd0, 2, 32'h10, 0, 3, 0, 0, 21, 0);
    do_load("R4 index flagged", 3'd0, 2, 32'h10, 1, 3, 0, 0, 22, 0);
    do_load("R5 clean clears", 3'd0, 2, 32'h10, 0, 0, 0, 0, 3, 0);
    // Float bank (R6)
    do_load("R6 float fault", 3'd1, 2, 32'h11, 0, 0, 0, 0, 5, 1);
    do_load("R6 float ignores int flag", 3'd0, 20, 32'h10, 0, 0, 0, 0, 9, 1);
    do_load("R6 float suppressed", 3'd0, 5, 32'h10, 0, 0, 0, 0, 11, 1);
    check_slot("R7 no write when control invalid", 0);

    // Enabled logging with limit 3
    log_ctl_valid = 1; log_enable = 0;
    do_load("R7 disabled no log", 3'd1, 2, 32'h41, 0, 0, 0, 0, 30, 0);
    check_slot("R7 slot0 still empty", 0);
    log_enable = 1; log_slot_limit = 4'd3;
    do_load("R8 log clean", 3'd2, 2, 32'h100, 0, 0, 0, 8, 24, 0);
    do_load("R9 log mem fault", 3'd1, 2, 32'h201, 0, 0, 0, 0, 25, 1);
    do_load("R9 log both faults", 3'd3, 2, 32'h304, 0, 0, 0, 0, 27, 0);
    do_load("R10 overflow", 3'd0, 2, 32'h400, 0, 0, 0, 0, 28, 0);
    check_slot("R8 slot0", 0);
    check_slot("R9 slot1", 1);
    check_slot("R9 slot2", 2);
    check_slot("R10 slot3 empty", 3);
    log_slot_limit = 4'd8;
    do_load("R7 raised limit", 3'd2, 2, 32'h500, 0, 0, 0, 0, 29, 0);
    check_slot("R7 slot3 written", 3);
    check_slot("R7 slot4 empty", 4);

    repeat (4) @(negedge clk);
    check("R11 scoreboard drained", 64'(sb_q.size()), 64'(0));
    finish_run();
  end
endmodule